// File: doc/BRIEF.md
# Two-Level Masked Interrupt Collector

This block gathers single-cycle event pulses from three source groups (packet handling, chip status and modem), each with eight sources, and keeps a sticky pending bit for every source. An active-low interrupt line is pulled low whenever a pending source is allowed through two levels of masking: a per-group enable and a per-source enable. The host sets the group enables with one write and the source enables with one write per group.

The host sees all pending bits at once on a read port, and a read-and-clear strobe empties them in a single cycle. After the clear the interrupt line goes high again and stays high until a new enabled event arrives. The live level of every source is passed straight through on a separate status output, whatever the enables hold. Pending bits latch even while masked, so turning on an enable later raises the interrupt at once for work that is already waiting.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset all pending bits and all enables are zero, and `irq_n_o` is high.
- R2: An event pulse on `evt_i[k]` sets `pend_o[k]` from the next cycle on, whatever the enables hold. The bit stays set until a clearing read. Bit k belongs to group k/8 (0 = packet handling, 1 = chip status, 2 = modem) and is source k%8 of that group.
- R3: `irq_n_o` is low exactly when at least one pending bit has both its source enable and its group enable set.
- R4: A pending bit with only one of its two enables set does not pull `irq_n_o` low.
- R5: A cycle with `rd_clr_i` high clears every pending bit from the next cycle on. `irq_n_o` is then high unless a new event arrived in that same cycle.
- R6: An event pulse in the same cycle as `rd_clr_i` is still pending after the clear.
- R7: `stat_o` equals `stat_i` in every cycle, whatever the enables and pending bits hold.
- R8: Setting an enable while the matching pending bit is already set pulls `irq_n_o` low in the cycle right after the write.
- R9: A source-enable write with `src_we_i[g]` high loads `src_wdata_i` into group g only. The other groups keep their source enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Event pulses, one per source |
| stat_i | input | 24 | Live source levels |
| grp_we_i | input | 1 | Write strobe for the group enables |
| grp_wdata_i | input | 3 | New group enables, bit g for group g |
| src_we_i | input | 3 | Per-group write strobes for the source enables |
| src_wdata_i | input | 8 | New source enables for the selected group |
| rd_clr_i | input | 1 | Read-and-clear strobe |
| pend_o | output | 24 | Pending bits |
| stat_o | output | 24 | Live source levels passed through |
| irq_n_o | output | 1 | Interrupt line, active low |

## Verification
The directed part starts with a single masked event and then turns the enables on one level at a time. This shows that a pending bit and a single level of enable cannot reach the line, while both levels together can (R4 against R3). It also shows that a late enable raises the line at once (R8). Separate steps line up an event with a clearing read, to show the new event is kept while older bits are dropped. A write to one group's source enables is followed by an event in a different group, to show the write did not spill into that group. The random part then applies sparse multi-bit event patterns, occasional enable writes and occasional clears. The bench model tracks which pending bits should survive and whether the line should be low, cycle by cycle.

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int NG = 3,
  parameter int GW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NG*GW-1:0] evt_i,
  input  logic [NG*GW-1:0] stat_i,
  input  logic             grp_we_i,
  input  logic [NG-1:0]    grp_wdata_i,
  input  logic [NG-1:0]    src_we_i,
  input  logic [GW-1:0]    src_wdata_i,
  input  logic             rd_clr_i,
  output logic [NG*GW-1:0] pend_o,
  output logic [NG*GW-1:0] stat_o,
  output logic             irq_n_o
);
  localparam int N = NG * GW;

  logic [N-1:0]  pend_q;
  logic [N-1:0]  src_en_q;
  logic [NG-1:0] grp_en_q;
  logic [NG-1:0] grp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      src_en_q <= '0;
      grp_en_q <= '0;
    end else begin
      pend_q <= (rd_clr_i ? '0 : pend_q) | evt_i;
      if (grp_we_i) grp_en_q <= grp_wdata_i;
      for (int g = 0; g < NG; g++)
        if (src_we_i[g]) src_en_q[g*GW +: GW] <= src_wdata_i;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_hit[g] = grp_en_q[g] & (|(pend_q[g*GW +: GW] & src_en_q[g*GW +: GW]));
  end

  assign pend_o  = pend_q;
  assign stat_o  = stat_i;
  assign irq_n_o = ~(|grp_hit);
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk #(
  parameter int N = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_i,
  input logic         rd_clr_i,
  input logic [N-1:0] pend_o,
  input logic         irq_n_o
);
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (pend_o == $past(evt_i)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && evt_i == '0) |=> irq_n_o);

  p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (pend_o != '0));
endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(.N(NG*GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_clr_i(rd_clr_i),
  .pend_o(pend_o), .irq_n_o(irq_n_o)
);

// File: tb/sim_irq_group_ctrl.sv
`timescale 1ns/100ps
module sim_irq_group_ctrl;
  localparam int NG = 3, GW = 8, N = NG*GW;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0, stat = '0;
  logic grp_we = 0; logic [NG-1:0] grp_wd = '0;
  logic [NG-1:0] src_we = '0; logic [GW-1:0] src_wd = '0;
  logic rd_clr = 0;
  logic [N-1:0] pend, stat_o; logic irq_n;

  int total = 0, bad = 0;
  logic [N-1:0] m_pend = '0, m_src = '0; logic [NG-1:0] m_grp = '0;

  irq_group_ctrl u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt), .stat_i(stat),
    .grp_we_i(grp_we), .grp_wdata_i(grp_wd), .src_we_i(src_we), .src_wdata_i(src_wd),
    .rd_clr_i(rd_clr), .pend_o(pend), .stat_o(stat_o), .irq_n_o(irq_n));

  always #2.5 clk = ~clk;

  function automatic logic exp_irq_n(logic [N-1:0] p, logic [N-1:0] s, logic [NG-1:0] ge);
    logic any = 0;
    for (int g = 0; g < NG; g++)
      if (ge[g] && |(p[g*GW +: GW] & s[g*GW +: GW])) any = 1;
    return !any;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [N-1:0] e, logic [N-1:0] s, logic gw, logic [NG-1:0] gd,
                     logic [NG-1:0] sw, logic [GW-1:0] sd, logic rc, string req);
    evt = e; stat = s; grp_we = gw; grp_wd = gd; src_we = sw; src_wd = sd; rd_clr = rc;
    #1 chk("R7 stat", 32'(stat_o), 32'(s));
    @(posedge clk);
    m_pend = (rc ? '0 : m_pend) | e;
    if (gw) m_grp = gd;
    for (int g = 0; g < NG; g++) if (sw[g]) m_src[g*GW +: GW] = sd;
    @(negedge clk);
    evt = '0; grp_we = 0; src_we = '0; rd_clr = 0;
    chk({req, " pend"}, 32'(pend), 32'(m_pend));
    chk({req, " irq_n"}, 32'(irq_n), 32'(exp_irq_n(m_pend, m_src, m_grp)));
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 pend", 32'(pend), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    rst_n = 1;
    @(negedge clk);
    cyc(24'h000020, 24'hA5A5A5, 0, 0, 0, 0, 0, "R2 masked latch");
    chk("R4 no enables", 32'(irq_n), 1);
    cyc(0, 24'h0F0F0F, 1, 3'b001, 0, 0, 0, "R4 group only");
    chk("R4 group only", 32'(irq_n), 1);
    cyc(0, 0, 1, 3'b000, 3'b001, 8'h20, 0, "R4 source only");
    chk("R4 source only", 32'(irq_n), 1);
    cyc(0, 0, 1, 3'b001, 0, 0, 0, "R8 late enable");
    chk("R8 late enable", 32'(irq_n), 0);
    chk("R3 both set", 32'(irq_n), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, "R5 clear");
    chk("R5 cleared", 32'(pend), 0);
    chk("R5 released", 32'(irq_n), 1);
    cyc(24'h000020, 0, 0, 0, 0, 0, 0, "R2 relatch");
    cyc(24'h000001, 0, 0, 0, 0, 0, 1, "R6 event with clear");
    chk("R6 kept", 32'(pend), 32'h000001);
    cyc(0, 0, 1, 3'b111, 3'b010, 8'hFF, 1, "R9 write group1");
    cyc(24'h000002, 0, 0, 0, 0, 0, 0, "R9 group0 untouched");
    chk("R9 group0 untouched", 32'(irq_n), 1);
    cyc(24'h000100, 0, 0, 0, 0, 0, 0, "R9 group1 written");
    chk("R9 group1 written", 32'(irq_n), 0);
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] e = N'($urandom & $urandom & $urandom);
      logic [N-1:0] s = N'($urandom);
      logic gw = ($urandom % 10) == 0;
      logic [NG-1:0] sw = (($urandom % 8) == 0) ? NG'($urandom) : '0;
      cyc(e, s, gw, NG'($urandom), sw, GW'($urandom), ($urandom % 8) == 0, "R3 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule